// File: doc/BRIEF.md
# Radix-2 Signed-Digit Carry-Free Adder

This block adds two N-digit redundant binary numbers whose digits each take the value -1, 0 or +1. It returns an (N+1)-digit sum in the same form. It is purely combinational, and its depth does not grow with N. No carry ever travels more than one digit position.

Each digit position works in two steps. In the first step, it splits the sum of its two operand digits into an interim digit and a transfer digit. To make that choice it looks only at its own digits and at whether either operand digit one position lower is negative. In the second step, it adds its interim digit to the transfer that comes up from the position below. The selection rule guarantees that this second step always lands in {-1, 0, +1}. The transfer from the highest position becomes the extra top result digit.

The block is meant to sit inside wider arithmetic datapaths, such as multiplier reduction trees or filter accumulators. Values stay in redundant form there until a final conversion elsewhere.

Top module: `sd_carry_free_adder`

## Requirements
- R1: Digit i of every operand and of the result occupies bits [2i+1:2i], with the upper bit flagging +1 and the lower bit flagging -1: code 10 is +1, 01 is -1 and 00 is 0. The result never contains code 11, and all-zero operands give an all-zero result.
- R2: For any legal operands, the result read with digit weights 2^i equals the exact sum of the two operands read the same way.
- R3: A position whose operand digits sum to +2 (or -2) has an interim digit of 0 and passes a transfer of +1 (or -1) upward.
- R4: A position whose digit sum is -1 has interim +1 and transfer -1 when either operand digit one position lower is -1. Otherwise it has interim -1 and transfer 0.
- R5: A position whose digit sum is +1 has interim +1 and transfer 0 when either operand digit one position lower is -1. Otherwise it has interim -1 and transfer +1.
- R6: A position whose digit sum is 0, including the pair +1 and -1, has interim 0 and transfer 0.
- R7: Each result digit i < N is the interim digit of position i plus the transfer from position i-1. This addition never leaves {-1, 0, +1}. Position 0 sees a non-negative lower neighbour and receives a transfer of 0, and result digit N is the transfer out of position N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*N | First signed-digit operand, N digits |
| op_b | input | 2*N | Second signed-digit operand, N digits |
| sum_o | output | 2*(N+1) | Signed-digit sum, N+1 digits |

## Verification
Isolated single-position patterns, with every digit-sum value from -2 to +2, are placed with and without a negative digit just below. These patterns separate the two branches of each selection rule and show whether the transfer lands in the right position. Top-digit patterns show that the last transfer becomes the extra result digit. An exhaustive sweep of a three-digit instance covers every combination of neighbouring digit sums, so any carry-creation fault would appear there. Random sixteen-digit operands check the exact value across long mixed-sign chains.

// File: rtl/sd_pkg.sv
package sd_pkg;
    typedef logic [1:0] sdig_t;

    localparam sdig_t SD_ZERO = 2'b00;
    localparam sdig_t SD_POS  = 2'b10;
    localparam sdig_t SD_NEG  = 2'b01;

    function automatic logic signed [2:0] sd_val(input sdig_t d);
        if (d[1])      sd_val = 3'sd1;
        else if (d[0]) sd_val = -3'sd1;
        else           sd_val = 3'sd0;
    endfunction

    function automatic sdig_t sd_enc(input logic signed [2:0] v);
        case (v)
            3'sd1:   sd_enc = SD_POS;
            -3'sd1:  sd_enc = SD_NEG;
            default: sd_enc = SD_ZERO;
        endcase
    endfunction
endpackage

// File: rtl/sd_pos_select.sv
module sd_pos_select
    import sd_pkg::*;
(
    input  sdig_t a_i,
    input  sdig_t b_i,
    input  sdig_t a_lo_i,
    input  sdig_t b_lo_i,
    output sdig_t interim_o,
    output sdig_t xfer_o
);
    logic signed [2:0] m;
    logic              lo_neg;

    always_comb begin
        m      = sd_val(a_i) + sd_val(b_i);
        lo_neg = a_lo_i[0] | b_lo_i[0];
        unique case (m)
            -3'sd2: begin interim_o = SD_ZERO; xfer_o = SD_NEG; end
            -3'sd1: begin
                if (lo_neg) begin interim_o = SD_POS; xfer_o = SD_NEG;  end
                else        begin interim_o = SD_NEG; xfer_o = SD_ZERO; end
            end
            3'sd1: begin
                if (lo_neg) begin interim_o = SD_POS; xfer_o = SD_ZERO; end
                else        begin interim_o = SD_NEG; xfer_o = SD_POS;  end
            end
            3'sd2:  begin interim_o = SD_ZERO; xfer_o = SD_POS;  end
            default: begin interim_o = SD_ZERO; xfer_o = SD_ZERO; end
        endcase
    end

    // R3 R4 R5 R6: split conserves the position sum
    always_comb begin
        if (!$isunknown({a_i, b_i, a_lo_i, b_lo_i})) begin
            a_r3_split_conserves: assert (2 * int'(sd_val(xfer_o)) + int'(sd_val(interim_o)) == int'(m));
            a_r1_select_codes: assert (interim_o != 2'b11 && xfer_o != 2'b11);
        end
    end
endmodule

// File: rtl/sd_digit_merge.sv
module sd_digit_merge
    import sd_pkg::*;
(
    input  sdig_t interim_i,
    input  sdig_t xfer_i,
    output sdig_t digit_o
);
    logic signed [2:0] s;

    always_comb begin
        s       = sd_val(interim_i) + sd_val(xfer_i);
        digit_o = sd_enc(s);
    end

    // R7: interim plus incoming transfer never leaves the digit set
    always_comb begin
        if (!$isunknown({interim_i, xfer_i})) begin
            a_r7_no_further_carry: assert (s >= -3'sd1 && s <= 3'sd1);
        end
    end
endmodule

// File: rtl/sd_carry_free_adder.sv
module sd_carry_free_adder
    import sd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [2*N-1:0]     op_a,
    input  logic [2*N-1:0]     op_b,
    output logic [2*(N+1)-1:0] sum_o
);
    localparam int OW = 2 * N;
    localparam int RW = 2 * (N + 1);

    sdig_t w_d [N];
    sdig_t t_d [N];
    sdig_t r_d [N+1];

    for (genvar i = 0; i < N; i++) begin : g_pos
        sdig_t a_lo, b_lo, t_lo;
        if (i == 0) begin : g_base
            assign a_lo = SD_ZERO;
            assign b_lo = SD_ZERO;
            assign t_lo = SD_ZERO;
        end else begin : g_mid
            assign a_lo = op_a[2*i-1 -: 2];
            assign b_lo = op_b[2*i-1 -: 2];
            assign t_lo = t_d[i-1];
        end

        sd_pos_select u_sel (
            .a_i       (op_a[2*i +: 2]),
            .b_i       (op_b[2*i +: 2]),
            .a_lo_i    (a_lo),
            .b_lo_i    (b_lo),
            .interim_o (w_d[i]),
            .xfer_o    (t_d[i])
        );

        sd_digit_merge u_merge (
            .interim_i (w_d[i]),
            .xfer_i    (t_lo),
            .digit_o   (r_d[i])
        );

        assign sum_o[2*i +: 2] = r_d[i];
    end

    assign r_d[N]          = t_d[N-1];
    assign sum_o[2*N +: 2] = r_d[N];

    function automatic longint op_value(input logic [OW-1:0] v);
        longint acc = 0;
        for (int k = 0; k < N; k++)
            acc += longint'(sd_val(v[2*k +: 2])) * (longint'(1) << k);
        return acc;
    endfunction

    function automatic longint res_value(input logic [RW-1:0] v);
        longint acc = 0;
        for (int k = 0; k <= N; k++)
            acc += longint'(sd_val(v[2*k +: 2])) * (longint'(1) << k);
        return acc;
    endfunction

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            // R2: exact value
            a_r2_value_exact: assert (res_value(sum_o) == op_value(op_a) + op_value(op_b));
            for (int k = 0; k <= N; k++) begin
                a_r1_result_code: assert (sum_o[2*k +: 2] != 2'b11);
            end
        end
    end
endmodule

// File: tb/sd_carry_free_adder_test.sv
module sd_carry_free_adder_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] a16, b16;
    logic [33:0] s16;
    logic [5:0]  a3, b3;
    logic [7:0]  s3;

    int tests = 0;
    int fails = 0;

    sd_carry_free_adder #(.N(16)) uut       (.op_a(a16), .op_b(b16), .sum_o(s16));
    sd_carry_free_adder #(.N(3))  uut_small (.op_a(a3),  .op_b(b3),  .sum_o(s3));

    function automatic int dv(input logic [1:0] d);
        if (d == 2'b10) return 1;
        if (d == 2'b01) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] dc(input int v);
        if (v == 1)  return 2'b10;
        if (v == -1) return 2'b01;
        return 2'b00;
    endfunction

    function automatic longint vv(input logic [63:0] v, input int nd);
        longint acc = 0;
        for (int k = 0; k < nd; k++) acc += longint'(dv(v[2*k +: 2])) * (longint'(1) << k);
        return acc;
    endfunction

    function automatic bit has_bad(input logic [63:0] v, input int nd);
        for (int k = 0; k < nd; k++) if (v[2*k +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk_val(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] s, input int nd);
        longint exp_v = vv(a, nd) + vv(b, nd);
        longint got_v = vv(s, nd + 1);
        tests++;
        if (got_v != exp_v || has_bad(s, nd + 1)) begin
            fails++;
            $display("FAIL %s value: actual %0d (raw %h) expected %0d", req, got_v, s, exp_v);
        end
    endtask

    task automatic chk_dig(input string req, input int idx, input logic [1:0] exp_c);
        tests++;
        if (s16[2*idx +: 2] !== exp_c) begin
            fails++;
            $display("FAIL %s digit %0d: actual %b expected %b", req, idx, s16[2*idx +: 2], exp_c);
        end
    endtask

    task automatic drive16(input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        a16 = a;
        b16 = b;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        a16 = '0; b16 = '0; a3 = '0; b3 = '0;
        @(negedge clk);
        // R1: zero operands give an all-zero result
        tests++;
        if (s16 !== 34'd0) begin
            fails++;
            $display("FAIL R1 zero: actual %h expected 0", s16);
        end

        // R3: sum +2 and -2
        drive16(32'h2, 32'h2);
        chk_dig("R3", 0, 2'b00); chk_dig("R3", 1, 2'b10); chk_val("R2", a16, b16, s16, 16);
        drive16(32'h1, 32'h1);
        chk_dig("R3", 0, 2'b00); chk_dig("R3", 1, 2'b01); chk_val("R2", a16, b16, s16, 16);

        // R4: sum -1, lower non-negative then lower negative
        drive16(32'h4, 32'h0);
        chk_dig("R4", 1, 2'b01); chk_dig("R4", 2, 2'b00);
        drive16(32'h5, 32'h0);
        chk_dig("R4", 0, 2'b01); chk_dig("R4", 1, 2'b10); chk_dig("R4", 2, 2'b01);
        chk_val("R2", a16, b16, s16, 16);

        // R5: sum +1, lower non-negative then lower negative
        drive16(32'h8, 32'h0);
        chk_dig("R5", 1, 2'b01); chk_dig("R5", 2, 2'b10);
        drive16(32'h9, 32'h0);
        chk_dig("R5", 0, 2'b01); chk_dig("R5", 1, 2'b10); chk_dig("R5", 2, 2'b00);
        chk_val("R2", a16, b16, s16, 16);

        // R6: +1 with -1 cancels
        drive16(32'h8, 32'h4);
        tests++;
        if (s16 !== 34'd0) begin
            fails++;
            $display("FAIL R6 cancel: actual %h expected 0", s16);
        end

        // R7: top transfer becomes digit N
        drive16(32'h8000_0000, 32'h8000_0000);
        chk_dig("R7", 16, 2'b10); chk_dig("R7", 15, 2'b00);
        drive16(32'hAAAA_AAAA, 32'hAAAA_AAAA);
        chk_val("R7", a16, b16, s16, 16);

        // R2: exhaustive three-digit sweep
        for (int ia = 0; ia < 27; ia++) begin
            for (int ib = 0; ib < 27; ib++) begin
                @(posedge clk);
                for (int k = 0, pa = ia, pb = ib; k < 3; k++, pa /= 3, pb /= 3) begin
                    a3[2*k +: 2] = dc((pa % 3) - 1);
                    b3[2*k +: 2] = dc((pb % 3) - 1);
                end
                @(negedge clk);
                chk_val("R2", 64'(a3), 64'(b3), 64'(s3), 3);
            end
        end

        // R2: random sixteen-digit operands
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            for (int k = 0; k < 16; k++) begin
                ra[2*k +: 2] = dc(int'($urandom_range(0, 2)) - 1);
                rb[2*k +: 2] = dc(int'($urandom_range(0, 2)) - 1);
            end
            drive16(ra, rb);
            chk_val("R2", 64'(a16), 64'(b16), 64'(s16), 16);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule